// File: doc/BRIEF.md
# Limited-Range Component Clamp

This block sits on an output pixel path and limits each of the three 12-bit colour components (red, green, blue) of a valid-qualified pixel stream. A 3-bit format code selects the behaviour. One group of codes clamps to the limited ("studio") range of 16..235 for a given bit depth. One code clamps each component to its own programmable lower and upper bounds. The remaining codes let the data through unchanged. A separate enable bypasses all clamping.

The programmable bounds are held in six internal registers: a lower and an upper bound for each of R, G and B. A single load strobe copies all six bound inputs into these registers. Reset gives the registers defaults. The clamped pixel and its valid flag leave the block through one register stage.

Top module: `clamp_limited_range`

## Requirements
- R1: `out_valid` follows `in_valid` with exactly one cycle of latency. While `rst_n` is low at a clock edge, `out_valid` and `out_pix` become 0.
- R2: When `clamp_en` is 0, `out_pix` equals the `in_pix` of the previous valid cycle, whatever `clamp_fmt` holds.
- R3: With `clamp_en` at 1, format code 0 (6-bit output, no clamping) and the unused codes 4, 5 and 6 pass every component through unchanged.
- R4: With `clamp_en` at 1, codes 1, 2 and 3 (8, 10 and 12 bits per component) clamp every component to the left-aligned limited range of 0x100..0xEB0 (16 and 235 scaled to the depth and placed at the top of the 12-bit word).
- R5: With `clamp_en` at 1, code 7 clamps each component to its own stored lower and upper bound.
- R6: After reset, every stored lower bound is 0x010 and every stored upper bound is 0xFEF.
- R7: A 1 on `bound_ld` at a clock edge stores all six bound inputs. While `bound_ld` is 0, changes on the bound inputs have no effect on the output.
- R8: The components are clamped independently. A component below its lower bound leaves as the lower bound, one above its upper bound leaves as the upper bound, and one inside the range is unchanged.
- R9: While `in_valid` is 0, `out_pix` holds its last value.
- Pixel packing: R in `in_pix[35:24]`, G in `[23:12]`, B in `[11:0]`; `out_pix` uses the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 36 | Input pixel {R,G,B}, 12 bits each |
| clamp_en | input | 1 | Clamp enable; 0 bypasses |
| clamp_fmt | input | 3 | Format code: 0 none, 1/2/3 limited 8/10/12 bit, 7 programmable |
| bound_ld | input | 1 | Stores the six bound inputs |
| lo_r | input | 12 | Red lower bound to store |
| hi_r | input | 12 | Red upper bound to store |
| lo_g | input | 12 | Green lower bound to store |
| hi_g | input | 12 | Green upper bound to store |
| lo_b | input | 12 | Blue lower bound to store |
| hi_b | input | 12 | Blue upper bound to store |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 36 | Clamped pixel {R,G,B} |

## Verification
A wrong decode of the format code appears on the next valid output pixel. The bench makes it visible by driving a component outside the limited range: the output then passes a value that should have been clamped, or clamps one that should have passed. A corrupted or mis-loaded bound register does not show at all until a pixel arrives under code 7. Its effect then appears one cycle later, and only on the affected component. The bench therefore probes each component's bounds on both sides. It also changes the bound inputs without a load strobe and confirms that the output does not move.

// File: rtl/clamp_pkg.sv
// Shared definitions for the limited-range component clamp.
// Assumes a 3-bit format code; code values are fixed by the block's contract.
package clamp_pkg;

    typedef enum logic [2:0] {
        CFMT_NONE  = 3'd0,
        CFMT_LIM8  = 3'd1,
        CFMT_LIM10 = 3'd2,
        CFMT_LIM12 = 3'd3,
        CFMT_PROG  = 3'd7
    } clamp_fmt_e;

    // Left-aligned limited-range level: 'level' at 8-bit scale placed in a word of width w.
    function automatic int unsigned lim_level(input int unsigned level, input int unsigned w);
        return level << (w - 8);
    endfunction

endpackage

// File: rtl/clamp_bound_regs.sv
// Storage for the per-component programmable clamp bounds.
// Assumes bounds are loaded all at once by a single strobe; reset loads defaults.
module clamp_bound_regs #(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned NUM_CH = 3,
    parameter logic [DATA_W-1:0] DEF_LO = 12'h010,
    parameter logic [DATA_W-1:0] DEF_HI = 12'hFEF,
    localparam int unsigned BUS_W = DATA_W * NUM_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [BUS_W-1:0] lo_in,
    input  logic [BUS_W-1:0] hi_in,
    output logic [BUS_W-1:0] lo_q,
    output logic [BUS_W-1:0] hi_q
);

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            // Hold one component's bound pair; defaults on reset, capture on load.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lo_q[c*DATA_W +: DATA_W] <= DEF_LO;
                    hi_q[c*DATA_W +: DATA_W] <= DEF_HI;
                end else if (ld) begin
                    lo_q[c*DATA_W +: DATA_W] <= lo_in[c*DATA_W +: DATA_W];
                    hi_q[c*DATA_W +: DATA_W] <= hi_in[c*DATA_W +: DATA_W];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/clamp_limit_sel.sv
// Decodes the enable and format code into per-component active limits.
// Assumes DATA_W >= 8 so the limited-range levels can be left-aligned.
module clamp_limit_sel
    import clamp_pkg::*;
#(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned NUM_CH = 3,
    localparam int unsigned BUS_W = DATA_W * NUM_CH
) (
    input  logic             en,
    input  logic [2:0]       fmt,
    input  logic [BUS_W-1:0] prog_lo,
    input  logic [BUS_W-1:0] prog_hi,
    output logic             active,
    output logic [BUS_W-1:0] lo,
    output logic [BUS_W-1:0] hi
);

    localparam logic [DATA_W-1:0] STD_LO = DATA_W'(lim_level(16, DATA_W));
    localparam logic [DATA_W-1:0] STD_HI = DATA_W'(lim_level(235, DATA_W));

    logic use_std;
    logic use_prog;

    // Classify the format code into standard-range, programmable or pass.
    always_comb begin
        use_std  = 1'b0;
        use_prog = 1'b0;
        case (fmt)
            CFMT_LIM8, CFMT_LIM10, CFMT_LIM12: use_std  = en;
            CFMT_PROG:                         use_prog = en;
            default: begin
                use_std  = 1'b0;
                use_prog = 1'b0;
            end
        endcase
        active = use_std | use_prog;
    end

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            // Pick the bound pair for one component.
            always_comb begin
                if (use_prog) begin
                    lo[c*DATA_W +: DATA_W] = prog_lo[c*DATA_W +: DATA_W];
                    hi[c*DATA_W +: DATA_W] = prog_hi[c*DATA_W +: DATA_W];
                end else begin
                    lo[c*DATA_W +: DATA_W] = STD_LO;
                    hi[c*DATA_W +: DATA_W] = STD_HI;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/clamp_component.sv
// Clamps one component to [lo, hi] when active, otherwise passes it.
// Assumes lo <= hi when active; if not, the lower bound test wins.
module clamp_component #(
    parameter int unsigned DATA_W = 12
) (
    input  logic              active,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    output logic [DATA_W-1:0] y
);

    // Compare against both bounds and select the result.
    always_comb begin
        if (!active)      y = x;
        else if (x < lo)  y = lo;
        else if (x > hi)  y = hi;
        else              y = x;
    end

endmodule

// File: rtl/clamp_limited_range.sv
// Top of the limited-range component clamp: bound storage, limit decode,
// one clamp per component and a single output register stage.
// Assumes components are packed with channel 0 (blue) in the low bits.
module clamp_limited_range #(
    parameter int unsigned DATA_W = 12,
    parameter logic [DATA_W-1:0] DEF_LO = 12'h010,
    parameter logic [DATA_W-1:0] DEF_HI = 12'hFEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [3*DATA_W-1:0] in_pix,
    input  logic                clamp_en,
    input  logic [2:0]          clamp_fmt,
    input  logic                bound_ld,
    input  logic [DATA_W-1:0]   lo_r,
    input  logic [DATA_W-1:0]   hi_r,
    input  logic [DATA_W-1:0]   lo_g,
    input  logic [DATA_W-1:0]   hi_g,
    input  logic [DATA_W-1:0]   lo_b,
    input  logic [DATA_W-1:0]   hi_b,
    output logic                out_valid,
    output logic [3*DATA_W-1:0] out_pix
);

    localparam int unsigned NUM_CH = 3;
    localparam int unsigned BUS_W  = DATA_W * NUM_CH;

    logic [BUS_W-1:0] lo_in_bus, hi_in_bus;
    logic [BUS_W-1:0] lo_stored, hi_stored;
    logic [BUS_W-1:0] lo_act, hi_act;
    logic             clamp_active;
    logic [BUS_W-1:0] clamped;

    assign lo_in_bus = {lo_r, lo_g, lo_b};
    assign hi_in_bus = {hi_r, hi_g, hi_b};

    clamp_bound_regs #(
        .DATA_W(DATA_W), .NUM_CH(NUM_CH), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
    ) u_bounds (
        .clk(clk), .rst_n(rst_n), .ld(bound_ld),
        .lo_in(lo_in_bus), .hi_in(hi_in_bus),
        .lo_q(lo_stored), .hi_q(hi_stored)
    );

    clamp_limit_sel #(
        .DATA_W(DATA_W), .NUM_CH(NUM_CH)
    ) u_sel (
        .en(clamp_en), .fmt(clamp_fmt),
        .prog_lo(lo_stored), .prog_hi(hi_stored),
        .active(clamp_active), .lo(lo_act), .hi(hi_act)
    );

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_clamp
            clamp_component #(.DATA_W(DATA_W)) u_comp (
                .active(clamp_active),
                .x(in_pix[c*DATA_W +: DATA_W]),
                .lo(lo_act[c*DATA_W +: DATA_W]),
                .hi(hi_act[c*DATA_W +: DATA_W]),
                .y(clamped[c*DATA_W +: DATA_W])
            );
        end
    endgenerate

    // Register the qualifier every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Register the clamped pixel on valid cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_pix <= '0;
        else if (in_valid) out_pix <= clamped;
    end

endmodule

// File: rtl/clamp_limited_range_chk.sv
// Port-level checker for the limited-range component clamp.
module clamp_limited_range_chk #(
    parameter int unsigned DATA_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [3*DATA_W-1:0] in_pix,
    input logic                clamp_en,
    input logic [2:0]          clamp_fmt,
    input logic                out_valid,
    input logic [3*DATA_W-1:0] out_pix
);

    localparam logic [DATA_W-1:0] LO_S = DATA_W'(16 << (DATA_W - 8));
    localparam logic [DATA_W-1:0] HI_S = DATA_W'(235 << (DATA_W - 8));

    logic std_fmt;
    logic pass_fmt;
    assign std_fmt  = (clamp_fmt == 3'd1) || (clamp_fmt == 3'd2) || (clamp_fmt == 3'd3);
    assign pass_fmt = (clamp_fmt == 3'd0) || (clamp_fmt == 3'd4) ||
                      (clamp_fmt == 3'd5) || (clamp_fmt == 3'd6);

    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_BYPASS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clamp_en) |=> out_pix == $past(in_pix)); // R2
    AST_BYPASS_FMT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && clamp_en && pass_fmt) |=> out_pix == $past(in_pix)); // R3
    AST_STD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && clamp_en && std_fmt) |=>
            (out_pix[35:24] >= LO_S && out_pix[35:24] <= HI_S &&
             out_pix[23:12] >= LO_S && out_pix[23:12] <= HI_S &&
             out_pix[11:0]  >= LO_S && out_pix[11:0]  <= HI_S)); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_pix)); // R9

endmodule

bind clamp_limited_range clamp_limited_range_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .clamp_en(clamp_en), .clamp_fmt(clamp_fmt),
    .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/tb_clamp_limited_range.sv
`timescale 1ns/1ps
module tb_clamp_limited_range;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [35:0] in_pix;
    logic        clamp_en;
    logic [2:0]  clamp_fmt;
    logic        bound_ld;
    logic [11:0] lo_r, hi_r, lo_g, hi_g, lo_b, hi_b;
    logic        out_valid;
    logic [35:0] out_pix;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    clamp_limited_range dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .clamp_en(clamp_en), .clamp_fmt(clamp_fmt), .bound_ld(bound_ld),
        .lo_r(lo_r), .hi_r(hi_r), .lo_g(lo_g), .hi_g(hi_g), .lo_b(lo_b), .hi_b(hi_b),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    // {en, fmt, R, G, B, expR, expG, expB}; code 7 rows rely on reset bounds (R6)
    localparam int NV = 10;
    localparam logic [75:0] VEC [NV] = '{
        {1'b1, 3'd1, 12'h000, 12'h800, 12'hFFF, 12'h100, 12'h800, 12'hEB0}, // R4 R8
        {1'b1, 3'd2, 12'h0FF, 12'h100, 12'hEB1, 12'h100, 12'h100, 12'hEB0}, // R4
        {1'b1, 3'd3, 12'hEB0, 12'h050, 12'h101, 12'hEB0, 12'h100, 12'h101}, // R4 R8
        {1'b1, 3'd0, 12'h000, 12'hFFF, 12'h123, 12'h000, 12'hFFF, 12'h123}, // R3
        {1'b1, 3'd5, 12'h001, 12'hFFE, 12'h0AA, 12'h001, 12'hFFE, 12'h0AA}, // R3
        {1'b1, 3'd7, 12'h00F, 12'hFF0, 12'h010, 12'h010, 12'hFEF, 12'h010}, // R5 R6
        {1'b0, 3'd1, 12'h000, 12'hFFF, 12'h555, 12'h000, 12'hFFF, 12'h555}, // R2
        {1'b0, 3'd7, 12'h005, 12'hFFA, 12'h800, 12'h005, 12'hFFA, 12'h800}, // R2
        {1'b1, 3'd6, 12'h000, 12'hFFF, 12'h007, 12'h000, 12'hFFF, 12'h007}, // R3
        {1'b1, 3'd7, 12'hFEF, 12'h011, 12'hFF0, 12'hFEF, 12'h011, 12'hFEF}  // R5 R8
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one valid pixel at a falling edge; the result is sampled at the next falling edge.
    task automatic send(input logic en, input logic [2:0] fmt, input logic [35:0] pix);
        @(negedge clk);
        in_valid  = 1'b1;
        clamp_en  = en;
        clamp_fmt = fmt;
        in_pix    = pix;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_pix = '0; clamp_en = 1'b0; clamp_fmt = 3'd0;
        bound_ld = 1'b0;
        lo_r = 12'h000; hi_r = 12'h000; lo_g = 12'h000; hi_g = 12'h000;
        lo_b = 12'h000; hi_b = 12'h000;
        repeat (3) @(negedge clk);
        check("R1 reset valid", 64'(out_valid), 64'd0);
        check("R1 reset pix", 64'(out_pix), 64'd0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][75], VEC[i][74:72], VEC[i][71:36]);
            check($sformatf("R1 vec%0d valid", i), 64'(out_valid), 64'd1);
            check($sformatf("R2-R5 vec%0d pix", i), 64'(out_pix), 64'(VEC[i][35:0]));
        end

        // R9: idle cycle keeps last output and drops valid
        @(negedge clk);
        in_pix = 36'hABCABCABC;
        @(negedge clk);
        check("R9 hold pix", 64'(out_pix), 64'({12'hFEF, 12'h011, 12'hFEF}));
        check("R1 idle valid", 64'(out_valid), 64'd0);

        // R7: load new bounds
        @(negedge clk);
        lo_r = 12'h200; hi_r = 12'h300; lo_g = 12'h000; hi_g = 12'hFFF;
        lo_b = 12'h400; hi_b = 12'h400; bound_ld = 1'b1;
        @(negedge clk);
        bound_ld = 1'b0;
        // change inputs without strobe: must be ignored
        lo_r = 12'h000; hi_r = 12'h001; lo_g = 12'h000; hi_g = 12'h001;
        lo_b = 12'h000; hi_b = 12'h001;
        send(1'b1, 3'd7, {12'h100, 12'h123, 12'h000});
        check("R7 R5 low side", 64'(out_pix), 64'({12'h200, 12'h123, 12'h400}));
        send(1'b1, 3'd7, {12'h3FF, 12'hFFF, 12'hFFF});
        check("R7 R8 high side", 64'(out_pix), 64'({12'h300, 12'hFFF, 12'h400}));
        send(1'b1, 3'd7, {12'h250, 12'h000, 12'h400});
        check("R8 in range", 64'(out_pix), 64'({12'h250, 12'h000, 12'h400}));

        // R6: reset restores default bounds
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset pix", 64'(out_pix), 64'd0);
        rst_n = 1'b1;
        send(1'b1, 3'd7, {12'h000, 12'hFFF, 12'h00F});
        check("R6 defaults", 64'(out_pix), 64'({12'h010, 12'hFEF, 12'h010}));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule